// File: doc/BRIEF.md
# Up/Down Timer with Count-Qualified Compare Channels

This block holds a free-running up/down timer and a set of compare channels that watch it. A channel reports a match only when the timer arrives at the channel's compare value by taking a count step. Writing the timer directly, or forcing it to zero, never produces a match, even if the new value equals a compare value. Each match raises a single-cycle pulse and sets an interrupt-pending bit. If a match arrives while that bit is still set and no acknowledge comes with it, the channel records a sticky overrun and keeps comparing.

The timer has three ways to change besides counting: a synchronous clear strobe from outside, a load port, and the block reset. Each channel has its own compare register, written over a shared data bus with one write enable per channel. The interrupt-pending bits are cleared by per-channel acknowledges, and the overrun flags are cleared by writing a one to them.

Top module: `cmp_timer_unit`

## Requirements
- R1: After synchronous reset the timer, every compare register, every match pulse, every pending bit and every overrun flag read zero.
- R2: With `cnt_en` high and no clear or load, the timer adds one when `cnt_down` is 0 and subtracts one when `cnt_down` is 1. The count wraps modulo 2^TMR_W in both directions. With `cnt_en` low the timer holds its value.
- R3: The sources that can change the timer take priority in this order: `tmr_clr` first, then `tmr_ld`, then counting. A load in the same cycle as a clear is discarded and the timer becomes 0.
- R4: `match_o[i]` is high for the one cycle that begins at the edge where the timer steps by counting into the compare value of channel i. If the timer then holds, the pulse does not repeat.
- R5: Loading the timer with a value equal to a compare value produces no match.
- R6: Clearing the timer to zero produces no match, even on a channel whose compare value is zero.
- R7: A count step that wraps (0xFFFF to 0 counting up, or 0 to 0xFFFF counting down) into a compare value produces a match.
- R8: A match sets `pend_o[i]`, and `irq_ack[i]` clears it. When an acknowledge and a match arrive in the same cycle, the bit stays set.
- R9: A match on a channel whose pending bit is set, with no acknowledge in that cycle, sets `ovr_o[i]`. The pending bit stays set and later matches still pulse. Writing 1 to `ovr_clr[i]` clears the flag. A new overrun in the same cycle as the clear leaves the flag set.
- R10: `cmp_we[i]` loads `cmp_wdata` into the compare register of channel i. A count step in the same cycle is compared against the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Advance the timer by one step this cycle |
| cnt_down | input | 1 | Step direction, 1 = decrement |
| tmr_ld | input | 1 | Load the timer from `tmr_ld_val` |
| tmr_ld_val | input | TMR_W | Value to load |
| tmr_clr | input | 1 | External strobe that forces the timer to zero |
| cmp_we | input | N_CH | Per-channel compare register write enables |
| cmp_wdata | input | TMR_W | Shared compare write data |
| irq_ack | input | N_CH | Per-channel pending acknowledge |
| ovr_clr | input | N_CH | Per-channel overrun clear, write one |
| tmr_o | output | TMR_W | Current timer value |
| match_o | output | N_CH | Per-channel single-cycle match pulses |
| pend_o | output | N_CH | Per-channel interrupt-pending bits |
| ovr_o | output | N_CH | Per-channel sticky overrun flags |

## Verification
Every result is a register output. A stimulus sampled at one rising edge shows up on `tmr_o`, `match_o`, `pend_o` and `ovr_o` right after that edge, and the pulse on `match_o` is gone one edge later. The bench drives its inputs on falling edges and advances a reference model at each rising edge. It then compares all four outputs on the following falling edge, so each check lands in the first cycle its result is due. The directed checks for the pulse width and for holding the timer sample one more falling edge later, which is the cycle in which the pulse must already be gone.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

    typedef enum logic [1:0] {
        TOP_HOLD  = 2'd0,
        TOP_STEP  = 2'd1,
        TOP_LOAD  = 2'd2,
        TOP_CLEAR = 2'd3
    } tmr_op_e;

    // Clear outranks load, load outranks counting.
    function automatic tmr_op_e pick_op(input logic clr, input logic ld, input logic en);
        if (clr)     return TOP_CLEAR;
        else if (ld) return TOP_LOAD;
        else if (en) return TOP_STEP;
        else         return TOP_HOLD;
    endfunction

endpackage

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter
    import cmp_timer_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             cnt_down,
    input  logic             tmr_ld,
    input  logic [TMR_W-1:0] tmr_ld_val,
    input  logic             tmr_clr,
    output logic [TMR_W-1:0] tmr_q,
    output logic [TMR_W-1:0] tmr_next,
    output logic             step_o
);

    typedef struct packed {
        logic [TMR_W-1:0] tmr;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    tmr_op_e    op;

    always_comb begin
        op     = pick_op(tmr_clr, tmr_ld, cnt_en);
        s_d    = s_q;
        step_o = 1'b0;
        unique case (op)
            TOP_CLEAR: s_d.tmr = '0;
            TOP_LOAD:  s_d.tmr = tmr_ld_val;
            TOP_STEP: begin
                step_o  = 1'b1;
                s_d.tmr = cnt_down ? s_q.tmr - 1'b1 : s_q.tmr + 1'b1;
            end
            default:   s_d.tmr = s_q.tmr;
        endcase
        if (rst) begin
            s_d    = '0;
            step_o = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign tmr_q    = s_q.tmr;
    assign tmr_next = s_d.tmr;

    assert_clear_wins_R3: assert property (@(posedge clk) disable iff (rst)
        $past(tmr_clr) |-> (tmr_q == '0));

    assert_step_up_R2: assert property (@(posedge clk) disable iff (rst)
        $past(step_o && !cnt_down) |-> (tmr_q == TMR_W'($past(tmr_q) + 1'b1)));

    assert_step_down_R2: assert property (@(posedge clk) disable iff (rst)
        $past(step_o && cnt_down) |-> (tmr_q == TMR_W'($past(tmr_q) - 1'b1)));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        $past(!cnt_en && !tmr_ld && !tmr_clr && !rst) |-> $stable(tmr_q));

endmodule

// File: rtl/cmp_timer_channel.sv
module cmp_timer_channel #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    input  logic [TMR_W-1:0] tmr_next_i,
    input  logic [TMR_W-1:0] tmr_i,
    input  logic             cmp_we_i,
    input  logic [TMR_W-1:0] cmp_wdata_i,
    input  logic             ack_i,
    input  logic             ovr_clr_i,
    output logic             match_o,
    output logic             pend_o,
    output logic             ovr_o
);

    typedef struct packed {
        logic [TMR_W-1:0] cmp;
        logic             match;
        logic             pend;
        logic             ovr;
    } chan_state_t;

    chan_state_t c_d, c_q;
    logic        hit;

    always_comb begin
        // Only a count step may hit; loads and clears never do.
        hit       = step_i && (tmr_next_i == c_q.cmp);
        c_d       = c_q;
        c_d.cmp   = cmp_we_i ? cmp_wdata_i : c_q.cmp;
        c_d.match = hit;
        c_d.pend  = hit | (c_q.pend & ~ack_i);
        c_d.ovr   = (hit & c_q.pend & ~ack_i) | (c_q.ovr & ~ovr_clr_i);
        if (rst) c_d = '0;
    end

    always_ff @(posedge clk) begin
        c_q <= c_d;
    end

    assign match_o = c_q.match;
    assign pend_o  = c_q.pend;
    assign ovr_o   = c_q.ovr;

    assert_match_by_step_R4: assert property (@(posedge clk) disable iff (rst)
        c_q.match |-> $past(step_i));

    assert_match_value_R4: assert property (@(posedge clk) disable iff (rst)
        c_q.match |-> (tmr_i == $past(c_q.cmp)));

    assert_pulse_needs_motion_R4: assert property (@(posedge clk) disable iff (rst)
        (c_q.match && $past(c_q.match)) |-> (tmr_i != $past(tmr_i)));

    assert_pend_follows_match_R8: assert property (@(posedge clk) disable iff (rst)
        c_q.match |-> c_q.pend);

    assert_ovr_source_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(c_q.ovr) |-> (c_q.match && $past(c_q.pend)));

    assert_ovr_keeps_pend_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(c_q.ovr) |-> c_q.pend);

endmodule

// File: rtl/cmp_timer_unit.sv
module cmp_timer_unit
    import cmp_timer_pkg::*;
#(
    parameter int TMR_W = 16,
    parameter int N_CH  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             cnt_down,
    input  logic             tmr_ld,
    input  logic [TMR_W-1:0] tmr_ld_val,
    input  logic             tmr_clr,
    input  logic [N_CH-1:0]  cmp_we,
    input  logic [TMR_W-1:0] cmp_wdata,
    input  logic [N_CH-1:0]  irq_ack,
    input  logic [N_CH-1:0]  ovr_clr,
    output logic [TMR_W-1:0] tmr_o,
    output logic [N_CH-1:0]  match_o,
    output logic [N_CH-1:0]  pend_o,
    output logic [N_CH-1:0]  ovr_o
);

    logic [TMR_W-1:0] tmr_cur;
    logic [TMR_W-1:0] tmr_nxt;
    logic             step;

    cmp_timer_counter #(.TMR_W(TMR_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .cnt_en     (cnt_en),
        .cnt_down   (cnt_down),
        .tmr_ld     (tmr_ld),
        .tmr_ld_val (tmr_ld_val),
        .tmr_clr    (tmr_clr),
        .tmr_q      (tmr_cur),
        .tmr_next   (tmr_nxt),
        .step_o     (step)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        cmp_timer_channel #(.TMR_W(TMR_W)) u_ch (
            .clk         (clk),
            .rst         (rst),
            .step_i      (step),
            .tmr_next_i  (tmr_nxt),
            .tmr_i       (tmr_cur),
            .cmp_we_i    (cmp_we[g]),
            .cmp_wdata_i (cmp_wdata),
            .ack_i       (irq_ack[g]),
            .ovr_clr_i   (ovr_clr[g]),
            .match_o     (match_o[g]),
            .pend_o      (pend_o[g]),
            .ovr_o       (ovr_o[g])
        );
    end

    assign tmr_o = tmr_cur;

    assert_no_match_on_load_R5: assert property (@(posedge clk) disable iff (rst)
        $past(tmr_ld || tmr_clr) |-> (match_o == '0));

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (tmr_o == '0 && match_o == '0 && pend_o == '0 && ovr_o == '0));

endmodule

// File: tb/sim_cmp_timer_unit.sv
module sim_cmp_timer_unit;

    localparam int W = 16;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cnt_en = 1'b0, cnt_down = 1'b0, tmr_ld = 1'b0, tmr_clr = 1'b0;
    logic [W-1:0] tmr_ld_val = '0, cmp_wdata = '0;
    logic [N-1:0] cmp_we = '0, irq_ack = '0, ovr_clr = '0;
    logic [W-1:0] tmr_o;
    logic [N-1:0] match_o, pend_o, ovr_o;

    int n_chk = 0;
    int n_bad = 0;

    // reference model
    logic [W-1:0] m_tmr = '0;
    logic [W-1:0] m_cmp [N];
    logic [N-1:0] m_match = '0, m_pend = '0, m_ovr = '0;

    always #5 clk = ~clk;

    cmp_timer_unit #(.TMR_W(W), .N_CH(N)) u0 (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .cnt_down(cnt_down),
        .tmr_ld(tmr_ld), .tmr_ld_val(tmr_ld_val), .tmr_clr(tmr_clr),
        .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .irq_ack(irq_ack),
        .ovr_clr(ovr_clr), .tmr_o(tmr_o), .match_o(match_o),
        .pend_o(pend_o), .ovr_o(ovr_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic [W-1:0] nt;
        logic         st;
        if (rst) begin
            m_tmr = '0; m_match = '0; m_pend = '0; m_ovr = '0;
            for (int i = 0; i < N; i++) m_cmp[i] = '0;
        end else begin
            st = 1'b0;
            if (tmr_clr)     nt = '0;
            else if (tmr_ld) nt = tmr_ld_val;
            else if (cnt_en) begin
                st = 1'b1;
                nt = cnt_down ? m_tmr - 1'b1 : m_tmr + 1'b1;
            end else nt = m_tmr;
            for (int i = 0; i < N; i++) begin
                logic h;
                h = st && (nt == m_cmp[i]);
                m_ovr[i]   = (h && m_pend[i] && !irq_ack[i]) || (m_ovr[i] && !ovr_clr[i]);
                m_pend[i]  = h || (m_pend[i] && !irq_ack[i]);
                m_match[i] = h;
                if (cmp_we[i]) m_cmp[i] = cmp_wdata;
            end
            m_tmr = nt;
        end
    endtask

    // one clock: model steps on the rising edge, outputs compared on the falling edge
    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R2 timer", 32'(tmr_o), 32'(m_tmr));
        chk("R4 match", 32'(match_o), 32'(m_match));
        chk("R8 pend", 32'(pend_o), 32'(m_pend));
        chk("R9 ovr", 32'(ovr_o), 32'(m_ovr));
        tmr_ld = 1'b0; tmr_clr = 1'b0; cmp_we = '0; irq_ack = '0; ovr_clr = '0;
    endtask

    task automatic wr_cmp(input int ch, input logic [W-1:0] v);
        cmp_we = '0;
        cmp_we[ch] = 1'b1;
        cmp_wdata = v;
        tick();
    endtask

    initial begin
        for (int i = 0; i < N; i++) m_cmp[i] = '0;
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 timer", 32'(tmr_o), 0);
        chk("R1 flags", 32'({match_o, pend_o, ovr_o}), 0);

        wr_cmp(0, 16'd5); wr_cmp(1, 16'd0); wr_cmp(2, 16'hFFFF); wr_cmp(3, 16'd3);

        // R10: step to 1 while ch3 compare changes 3 -> 1; old value applies
        cnt_en = 1'b1; cmp_we = 4'b1000; cmp_wdata = 16'd1;
        tick();
        chk("R10 same-cycle write uses old", 32'(match_o[3]), 0);
        chk("R2 up step", 32'(tmr_o), 1);
        tick(); tick(); tick();           // timer 2,3,4
        chk("R10 new compare not hit by old value", 32'(match_o[3]), 0);
        tick();                           // timer 5
        chk("R4 match ch0 at 5", 32'(match_o), 32'h1);
        chk("R8 pend ch0", 32'(pend_o[0]), 1);
        cnt_en = 1'b0;
        tick();
        chk("R4 pulse one cycle while holding", 32'(match_o), 0);
        chk("R2 hold", 32'(tmr_o), 5);
        irq_ack = 4'b0001;
        tick();
        chk("R8 ack clears", 32'(pend_o[0]), 0);

        // R5 load equal to compare value
        tmr_ld = 1'b1; tmr_ld_val = 16'd5;
        tick();
        chk("R5 load no match", 32'(match_o), 0);
        chk("R5 timer loaded", 32'(tmr_o), 5);
        // R6 clear with ch1 compare 0
        tmr_clr = 1'b1;
        tick();
        chk("R6 clear no match", 32'(match_o), 0);
        // R3 clear beats load
        tmr_ld = 1'b1; tmr_ld_val = 16'd9; tmr_clr = 1'b1;
        tick();
        chk("R3 clear wins", 32'(tmr_o), 0);
        // R3 load beats count
        cnt_en = 1'b1; tmr_ld = 1'b1; tmr_ld_val = 16'd40;
        tick();
        chk("R3 load beats count", 32'(tmr_o), 40);

        // R7 wrap down into 0xFFFF and up into 0
        tmr_clr = 1'b1; tick();
        cnt_down = 1'b1;
        tick();
        chk("R7 wrap down timer", 32'(tmr_o), 32'hFFFF);
        chk("R7 wrap down match ch2", 32'(match_o), 32'h4);
        cnt_down = 1'b0;
        tick();
        chk("R7 wrap up match ch1", 32'(match_o), 32'h2);
        irq_ack = 4'b0110; cnt_en = 1'b0;
        tick();

        // R8 ack and match together keep pend; no overrun
        tmr_ld = 1'b1; tmr_ld_val = 16'd4; tick();
        cnt_en = 1'b1; tick();            // ch0 match, pend set
        cnt_en = 1'b0; tmr_ld = 1'b1; tmr_ld_val = 16'd4; tick();
        cnt_en = 1'b1; irq_ack = 4'b0001;
        tick();
        chk("R8 ack+match keeps pend", 32'(pend_o[0]), 1);
        chk("R9 no overrun when acked", 32'(ovr_o[0]), 0);
        // R9 overrun
        cnt_en = 1'b0; tmr_ld = 1'b1; tmr_ld_val = 16'd4; tick();
        cnt_en = 1'b1;
        tick();
        chk("R9 overrun set", 32'(ovr_o[0]), 1);
        chk("R9 pend kept", 32'(pend_o[0]), 1);
        chk("R9 match still pulses", 32'(match_o[0]), 1);
        cnt_en = 1'b0; ovr_clr = 4'b0001;
        tick();
        chk("R9 write-one clears", 32'(ovr_o[0]), 0);
        tmr_ld = 1'b1; tmr_ld_val = 16'd4; tick();
        cnt_en = 1'b1; ovr_clr = 4'b0001;
        tick();
        chk("R9 set wins over clear", 32'(ovr_o[0]), 1);

        // sweeps: full wrap up then down with periodic acks
        irq_ack = '1; ovr_clr = '1; tmr_clr = 1'b1; cnt_en = 1'b0; tick();
        cnt_en = 1'b1; cnt_down = 1'b0;
        for (int k = 0; k < 65540; k++) begin
            if (k % 7 == 0) irq_ack[0] = 1'b1;
            tick();
        end
        cnt_down = 1'b1;
        for (int k = 0; k < 65540; k++) begin
            if (k % 11 == 0) irq_ack[3] = 1'b1;
            tick();
        end
        chk("R9 ch2 overran after two passes", 32'(ovr_o[2]), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R1..all actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule